// File: doc/BRIEF.md
# Next-PC and Branch-Target Unit

This block holds the program counter of a 32-bit instruction stream in which every instruction is one aligned word. Each cycle it reads the decoded instruction word and the two source-register values that the register file supplies for that instruction. It picks the address of the next instruction and loads that address into the PC on the next clock edge. There is no delay slot, so a redirect takes effect in the cycle after the instruction that causes it.

The block handles five kinds of control flow. Straight-line code advances by one word. Conditional branches are relative to the following word: equal, not-equal and sign-negative. Direct jumps keep the top segment bits of the PC. Linking calls report a return address that the register file writes into register 31. Indirect jumps take their address from a register, and an unaligned register target is flagged. The register file, the ALU and data memory sit outside the block.

Top module: `nextpc_unit`

## Requirements
- R1: A synchronous reset, active high on `rst`, loads the PC with RESET_VEC (default 0x0040_0000). The new value is visible after the clock edge at which `rst` is sampled high.
- R2: An instruction that is not a control transfer gives `next_pc` = PC+4 and `link_we` = 0. Non-control instructions are opcode (bits 31:26) above 0x05, opcode 0x00 with function (bits 5:0) other than 0x08/0x09, and opcode 0x01 with bits 20:16 non-zero.
- R3: Opcode 0x04 (equal branch) is taken when `rs_val` == `rt_val`. When not taken, `next_pc` is PC+4.
- R4: Opcode 0x05 (not-equal branch) is taken when `rs_val` != `rt_val`. When not taken, `next_pc` is PC+4.
- R5: Opcode 0x01 with bits 20:16 equal to zero is taken when bit 31 of `rs_val` is set. The same opcode with any other value in bits 20:16 is sequential.
- R6: The target of a taken branch is PC + 4 + 4 × sext(bits 15:0). This holds at both ends of the offset range, 0x7FFF and 0x8000.
- R7: Opcode 0x02 jumps to {PC[31:28], bits 25:0, 2'b00}.
- R8: Opcode 0x03 jumps to the same target as R7 and raises `link_we`. `link_val` is PC+4.
- R9: Opcode 0x00 with function 0x08 jumps to `rs_val` with its two low bits forced to zero, and does not link.
- R10: Opcode 0x00 with function 0x09 jumps as in R9, raises `link_we` and gives `link_val` = PC+4.
- R11: `misalign` is high only for the register jumps of R9/R10 whose `rs_val[1:0]` is non-zero. It stays low for every other instruction, whatever `rs_val` holds.
- R12: Out of reset, the PC after each clock edge equals the `next_pc` presented before that edge. A redirect therefore takes effect on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address selected for the next cycle |
| link_we | output | 1 | Write return address into register 31 |
| link_val | output | 32 | Return address (PC+4) |
| misalign | output | 1 | Register-jump target had non-zero low bits |

## Verification
The PC register is the only state, so a wrong internal value appears on `pc` in the cycle right after the faulty edge. It then spreads into `next_pc` and `link_val` in the same cycle, because both are computed from the PC. Every case reaches its start address through a register jump, so the cycle in which the PC lands there is checked as well. Each redirect is then checked twice: once on the combinational `next_pc` before the edge, and once on `pc` one cycle later. A lost or late update is therefore caught within a single cycle. The bench also covers both ends of the branch offset range, the kept segment bits of a direct jump, and unaligned register targets.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

   localparam int INSTR_W = 32;
   localparam int IMM_W   = 16;
   localparam int TGT_W   = 26;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_REGIMM  = 6'h01;
   localparam logic [5:0] OP_JMP     = 6'h02;
   localparam logic [5:0] OP_JMPLNK  = 6'h03;
   localparam logic [5:0] OP_BREQ    = 6'h04;
   localparam logic [5:0] OP_BRNE    = 6'h05;
   localparam logic [5:0] FN_JREG    = 6'h08;
   localparam logic [5:0] FN_JREGLNK = 6'h09;

   typedef enum logic [2:0] {
      CK_SEQ,
      CK_BEQ,
      CK_BNE,
      CK_BNEG,
      CK_JDIR,
      CK_JDIR_LINK,
      CK_JREG,
      CK_JREG_LINK
   } ctl_kind_e;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
   import nextpc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output ctl_kind_e          kind,
   output logic [IMM_W-1:0]   imm,
   output logic [TGT_W-1:0]   tgt
);
   logic [5:0] opcode;
   logic [5:0] funct;
   logic [4:0] sel_rt;

   assign opcode = instr[31:26];
   assign funct  = instr[5:0];
   assign sel_rt = instr[20:16];
   assign imm    = instr[IMM_W-1:0];
   assign tgt    = instr[TGT_W-1:0];

   always_comb begin
      kind = CK_SEQ;
      unique case (opcode)
         OP_SPECIAL: begin
            if (funct == FN_JREG)         kind = CK_JREG;
            else if (funct == FN_JREGLNK) kind = CK_JREG_LINK;
         end
         OP_REGIMM:  if (sel_rt == 5'd0) kind = CK_BNEG;
         OP_JMP:     kind = CK_JDIR;
         OP_JMPLNK:  kind = CK_JDIR_LINK;
         OP_BREQ:    kind = CK_BEQ;
         OP_BRNE:    kind = CK_BNE;
         default:    kind = CK_SEQ;
      endcase
   end
endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
   import nextpc_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  ctl_kind_e        kind,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   output logic             taken
);
   logic same;
   assign same = (rs_val == rt_val);

   always_comb begin
      case (kind)
         CK_BEQ:  taken = same;
         CK_BNE:  taken = !same;
         CK_BNEG: taken = rs_val[XLEN-1];
         default: taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
   import nextpc_pkg::*;
#(
   parameter int XLEN            = 32,
   parameter bit CLEAR_REG_LOW   = 1'b1
)(
   input  logic [XLEN-1:0]  pc,
   input  logic [IMM_W-1:0] imm,
   input  logic [TGT_W-1:0] tgt,
   input  logic [XLEN-1:0]  rs_val,
   output logic [XLEN-1:0]  pc_plus4,
   output logic [XLEN-1:0]  br_tgt,
   output logic [XLEN-1:0]  jdir_tgt,
   output logic [XLEN-1:0]  jreg_tgt,
   output logic             jreg_odd
);
   localparam int SEG_W = XLEN - TGT_W - 2;
   localparam int EXT_W = XLEN - IMM_W - 2;

   logic [XLEN-1:0] offs;

   assign pc_plus4 = pc + XLEN'(4);
   assign offs     = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign br_tgt   = pc_plus4 + offs;
   assign jdir_tgt = {pc[XLEN-1 -: SEG_W], tgt, 2'b00};
   assign jreg_odd = |rs_val[1:0];

   generate
      if (CLEAR_REG_LOW) begin : g_clear
         assign jreg_tgt = {rs_val[XLEN-1:2], 2'b00};
      end else begin : g_pass
         assign jreg_tgt = rs_val;
      end
   endgenerate
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
   import nextpc_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter logic [31:0] RESET_VEC     = 32'h0040_0000,
   parameter bit          CLEAR_REG_LOW = 1'b1
)(
   input  logic            clk,
   input  logic            rst,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] next_pc,
   output logic            link_we,
   output logic [XLEN-1:0] link_val,
   output logic            misalign
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("nextpc_unit: XLEN must be 32");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("nextpc_unit: RESET_VEC must be word aligned");
      end
   endgenerate

   ctl_kind_e        kind;
   logic [IMM_W-1:0] imm;
   logic [TGT_W-1:0] tgt;
   logic             taken;
   logic [XLEN-1:0]  pc_plus4, br_tgt, jdir_tgt, jreg_tgt;
   logic             jreg_odd;
   logic [XLEN-1:0]  pc_q;

   nextpc_decode u_dec (
      .instr (instr),
      .kind  (kind),
      .imm   (imm),
      .tgt   (tgt)
   );

   nextpc_cond #(.XLEN(XLEN)) u_cond (
      .kind   (kind),
      .rs_val (rs_val),
      .rt_val (rt_val),
      .taken  (taken)
   );

   nextpc_target #(.XLEN(XLEN), .CLEAR_REG_LOW(CLEAR_REG_LOW)) u_tgt (
      .pc       (pc_q),
      .imm      (imm),
      .tgt      (tgt),
      .rs_val   (rs_val),
      .pc_plus4 (pc_plus4),
      .br_tgt   (br_tgt),
      .jdir_tgt (jdir_tgt),
      .jreg_tgt (jreg_tgt),
      .jreg_odd (jreg_odd)
   );

   always_comb begin
      next_pc  = pc_plus4;
      link_we  = 1'b0;
      misalign = 1'b0;
      case (kind)
         CK_BEQ, CK_BNE, CK_BNEG: if (taken) next_pc = br_tgt;
         CK_JDIR:      next_pc = jdir_tgt;
         CK_JDIR_LINK: begin
            next_pc = jdir_tgt;
            link_we = 1'b1;
         end
         CK_JREG: begin
            next_pc  = jreg_tgt;
            misalign = jreg_odd;
         end
         CK_JREG_LINK: begin
            next_pc  = jreg_tgt;
            misalign = jreg_odd;
            link_we  = 1'b1;
         end
         default: next_pc = pc_plus4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_VEC;
      else     pc_q <= next_pc;
   end

   assign pc       = pc_q;
   assign link_val = pc_plus4;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
   parameter int          XLEN      = 32,
   parameter logic [31:0] RESET_VEC = 32'h0040_0000
)(
   input logic            clk,
   input logic            rst,
   input logic [31:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic [XLEN-1:0] next_pc,
   input logic            link_we,
   input logic [XLEN-1:0] link_val,
   input logic            misalign
);
   logic [5:0] op;
   logic [5:0] fn;
   assign op = instr[31:26];
   assign fn = instr[5:0];

   AST_RESET_LOADS_VEC: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pc == RESET_VEC); // R1
   AST_PC_TRACKS_NEXT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> pc == $past(next_pc)); // R12
   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (op > 6'h05) |-> (next_pc == pc + 32'd4 && !link_we)); // R2
   AST_BRANCH_NO_LINK: assert property (@(posedge clk) disable iff (rst)
      (op == 6'h01 || op == 6'h04 || op == 6'h05) |-> !link_we); // R3
   AST_LINK_RETURN: assert property (@(posedge clk) disable iff (rst)
      link_we |-> link_val == pc + 32'd4); // R8
   AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      next_pc[1:0] == 2'b00); // R9
   AST_MISALIGN_SOURCE: assert property (@(posedge clk) disable iff (rst)
      misalign |-> (op == 6'h00 && (fn == 6'h08 || fn == 6'h09))); // R11
endmodule

bind nextpc_unit nextpc_unit_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (.*);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_val = 32'h0;
   logic [31:0] rt_val = 32'h0;
   logic [31:0] pc, next_pc, link_val;
   logic        link_we, misalign;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nextpc_unit u_dut (
      .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
      .pc(pc), .next_pc(next_pc), .link_we(link_we), .link_val(link_val),
      .misalign(misalign)
   );

   typedef struct packed {
      logic [31:0] pc0;
      logic [31:0] ins;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] exp_pc;
      logic        we;
      logic        mis;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_0100, 32'h0085_1021, 32'h0,         32'h0, 32'h0040_0104, 1'b0, 1'b0, 8'd2},  // R2 plain op
      '{32'h0040_0100, 32'h1022_0002, 32'h5,         32'h5, 32'h0040_010C, 1'b0, 1'b0, 8'd3},  // R3 taken
      '{32'h0040_0100, 32'h1022_0002, 32'h5,         32'h6, 32'h0040_0104, 1'b0, 1'b0, 8'd3},  // R3 not taken
      '{32'h0040_0100, 32'h1422_FFFF, 32'h1,         32'h2, 32'h0040_0100, 1'b0, 1'b0, 8'd4},  // R4 taken back
      '{32'h0040_0100, 32'h1422_FFFF, 32'h7,         32'h7, 32'h0040_0104, 1'b0, 1'b0, 8'd4},  // R4 not taken
      '{32'h0040_0100, 32'h0420_0010, 32'h8000_0000, 32'h0, 32'h0040_0144, 1'b0, 1'b0, 8'd5},  // R5 taken
      '{32'h0040_0100, 32'h0420_0010, 32'h7FFF_FFFF, 32'h0, 32'h0040_0104, 1'b0, 1'b0, 8'd5},  // R5 not taken
      '{32'h0040_0100, 32'h0421_0010, 32'h8000_0000, 32'h0, 32'h0040_0104, 1'b0, 1'b0, 8'd5},  // R5 rt field set
      '{32'h0040_0000, 32'h1022_7FFF, 32'h9,         32'h9, 32'h0042_0000, 1'b0, 1'b0, 8'd6},  // R6 max offset
      '{32'h0042_0000, 32'h1022_8000, 32'h9,         32'h9, 32'h0040_0004, 1'b0, 1'b0, 8'd6},  // R6 min offset
      '{32'h1000_0000, 32'h0BFF_FFFF, 32'h0,         32'h0, 32'h1FFF_FFFC, 1'b0, 1'b0, 8'd7},  // R7 segment kept
      '{32'hA000_0010, 32'h0C00_0040, 32'h0,         32'h0, 32'hA000_0100, 1'b1, 1'b0, 8'd8},  // R8 link call
      '{32'h0040_0100, 32'h0020_0008, 32'h0040_0200, 32'h0, 32'h0040_0200, 1'b0, 1'b0, 8'd9},  // R9 aligned
      '{32'h0040_0100, 32'h0020_0008, 32'h0040_0203, 32'h0, 32'h0040_0200, 1'b0, 1'b1, 8'd11}, // R11 odd target
      '{32'h0040_0300, 32'h0020_F809, 32'h0050_0002, 32'h0, 32'h0050_0000, 1'b1, 1'b1, 8'd10}, // R10 link reg
      '{32'h0040_0100, 32'h0085_1021, 32'h0000_0003, 32'h0, 32'h0040_0104, 1'b0, 1'b0, 8'd11}  // R11 no flag
   };

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   task automatic check1(input string req, input string what,
                         input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      string tag;
      // reset state (R1)
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check32("R1", "pc after reset", pc, 32'h0040_0000);

      for (int i = 0; i < NV; i++) begin
         tag = $sformatf("R%0d", VECS[i].req);
         // move to start address with a register jump
         instr  = 32'h0020_0008;
         rs_val = VECS[i].pc0;
         @(negedge clk);
         check32("R12", "pc reaches start", pc, VECS[i].pc0);
         instr  = VECS[i].ins;
         rs_val = VECS[i].rs;
         rt_val = VECS[i].rt;
         #2;
         check32(tag, "next_pc", next_pc, VECS[i].exp_pc);
         check1(tag, "link_we", link_we, VECS[i].we);
         check1(tag, "misalign", misalign, VECS[i].mis);
         if (VECS[i].we) check32(tag, "link_val", link_val, VECS[i].pc0 + 32'd4);
         @(negedge clk);
         check32("R12", "pc after edge", pc, VECS[i].exp_pc);
      end

      // R12: back-to-back redirects, no delay slot
      instr = 32'h0800_0040;              // direct jump to 0x0000_0100 segment of pc
      @(negedge clk);
      check32("R12", "first jump", pc, {pc[31:28], 28'h000_0100});
      instr = 32'h1022_0003; rs_val = 32'h1; rt_val = 32'h1;
      @(negedge clk);
      check32("R12", "branch right after jump", pc, 32'h0000_0110);

      // R1: reset wins over a jump presented in the same cycle
      instr = 32'h0C00_0400;
      rst   = 1'b1;
      @(negedge clk);
      rst   = 1'b0;
      check32("R1", "pc after mid-run reset", pc, 32'h0040_0000);
      // R2: opcode 0 with an unrelated function code walks on
      instr = 32'h0000_000A; rs_val = 32'h0;
      @(negedge clk);
      check32("R2", "special non-jump", pc, 32'h0040_0004);
      check1("R2", "no link", link_we, 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule